// File: doc/BRIEF.md
# Multi-Channel Compare System Timer

A memory-mapped timer that keeps one free-running up-counter. Four compare channels share that counter. The counter advances once per prescaled tick. Each channel watches for the tick on which the counter steps onto its programmed compare value. On that tick the channel latches a pending flag and raises its own interrupt line.

A match neither stops nor reloads the counter. Periodic or one-shot behaviour is therefore left to software, which rewrites compare values or clears channel enables. Software may also load the counter directly, for example to restore a saved count after a low-power interval.

A debug-halt input can freeze counting, but only when the freeze-permit control bit is set. Register access uses a simple single-cycle port. Writes take effect on the clock edge. Read data is combinational from the address while the read strobe is high, and reads zero otherwise.

The tick source is a three-state machine:
- **TB_OFF**: the enable bit is clear; the divider is held at zero.
- **TB_RUN**: counting.
- **TB_HALT**: enabled but frozen by debug; the divider and counter hold.

Transitions are evaluated every clock:
- *disable* (any state to TB_OFF when the enable bit clears);
- *start* (TB_OFF to TB_RUN);
- *freeze* (TB_RUN or TB_OFF to TB_HALT when enabled, freeze is permitted and debug-halt is high);
- *thaw* (TB_HALT to TB_RUN when debug-halt drops or freeze is no longer permitted).

Top module: `mctimer_top`

## Requirements
- R1: After synchronous reset every register reads zero and all interrupt lines are low.
- R2: The control register at offset 0x00 has bit 0 = timer enable, bit 1 = freeze permit and bits 15:8 = prescale field. With bit 0 clear, the counter holds its value.
- R3: With prescale field k, the counter at offset 0x04 increments once every k+1 module clocks (k=0 gives every clock, k=255 gives every 256 clocks).
- R4: With bit 0 and bit 1 both set, a high debug-halt input freezes the counter. With bit 1 clear, debug-halt has no effect on counting.
- R5: A write to offset 0x04 loads the counter with the written value. Counting continues from it, and the step after 0xFFFFFFFF is 0x00000000.
- R6: Channel n (n=0..3) has its registers at 0x10+0x10*n: control at +0x0 (bit 0 = compare enable), flag at +0x4 (bit 0) and compare value at +0x8. When the channel is enabled and the counter steps onto the compare value, the flag sets. Interrupt line n equals flag AND enable.
- R7: Writing 1 to flag bit 0 clears the flag, and writing 0 leaves it unchanged. A match on the same edge as the clear wins.
- R8: Clearing a channel's enable masks its interrupt line but keeps its pending flag, and re-enabling exposes the flag again.
- R9: A match is detected only on the tick that steps the counter onto the compare value. Neither a counter load onto that value nor the counter resting on it between prescaled ticks sets the flag.
- R10: Unmapped or misaligned offsets read zero, as do reserved bits. Mapped registers read back what was written in their defined fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, acts on the rising edge |
| rd_en | input | 1 | Read strobe, gates read data |
| rdata | output | 32 | Read data (combinational) |
| dbg_halt | input | 1 | Debug-halt request |
| irq | output | 4 | Per-channel interrupt lines |

## Verification
Several properties are checked on every cycle next to the logic:
- the counter holds in the off and halted states;
- a counter load lands on the next edge;
- a flag rises only on an enabled counting step;
- a write of one clears the flag;
- a pending flag survives every cycle without such a write.

Some behaviours only the bench scenarios can show:
- the exact tick spacing for several prescale values;
- freeze being ignored without the permit bit;
- wrap through zero;
- the absence of a match on a load or while the counter rests on the compare value;
- masking and re-exposing an interrupt;
- the register map, including reserved and unmapped reads.

// File: rtl/mct_pkg.sv
package mct_pkg;
    typedef enum logic [1:0] {
        TB_OFF  = 2'd0,
        TB_RUN  = 2'd1,
        TB_HALT = 2'd2
    } tb_state_e;

    localparam int OFF_CTRL   = 'h00;
    localparam int OFF_COUNT  = 'h04;
    localparam int SUB_CHCTL  = 'h0;
    localparam int SUB_CHFLAG = 'h4;
    localparam int SUB_CHCMP  = 'h8;
endpackage

// File: rtl/mct_timebase.sv
module mct_timebase
    import mct_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             frz_i,
    input  logic             dbg_i,
    input  logic [PSC_W-1:0] psc_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] nxt_o,
    output logic             step_o
);
    tb_state_e        state_q, state_d;
    logic [PSC_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TB_OFF: begin
                if (en_i && frz_i && dbg_i) state_d = TB_HALT;
                else if (en_i)              state_d = TB_RUN;
            end
            TB_RUN: begin
                if (!en_i)                  state_d = TB_OFF;
                else if (frz_i && dbg_i)    state_d = TB_HALT;
            end
            TB_HALT: begin
                if (!en_i)                  state_d = TB_OFF;
                else if (!(frz_i && dbg_i)) state_d = TB_RUN;
            end
            default:                        state_d = TB_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= TB_OFF;
        else     state_q <= state_d;
    end

    always_comb begin
        tick   = 1'b0;
        unique case (state_q)
            TB_RUN:  tick = (div_q >= psc_i);
            TB_OFF:  tick = 1'b0;
            TB_HALT: tick = 1'b0;
            default: tick = 1'b0;
        endcase
        step_o = tick && !load_i;
    end

    always_ff @(posedge clk) begin
        if (rst || load_i || state_q == TB_OFF) div_q <= '0;
        else if (tick)                          div_q <= '0;
        else if (state_q == TB_RUN)             div_q <= div_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (tick)   cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
    assign nxt_o = cnt_q + 1'b1;

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == TB_OFF && !load_i) |=> $stable(cnt_q)); // R2
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == TB_HALT && !load_i) |=> $stable(cnt_q)); // R4
    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == $past(load_val_i))); // R5
    AST_DIV_HALT: assert property (@(posedge clk) disable iff (rst)
        (state_q == TB_HALT && !load_i) |=> $stable(div_q)); // R4
endmodule

// File: rtl/mct_channel.sv
module mct_channel #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic [CNT_W-1:0] nxt_i,
    input  logic             ctl_we,
    input  logic             flag_we,
    input  logic             cmp_we,
    input  logic             wbit_i,
    input  logic [CNT_W-1:0] wval_i,
    output logic             en_o,
    output logic             flag_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             irq_o
);
    logic             en_q, flag_q, hit;
    logic [CNT_W-1:0] cmp_q;

    assign hit = step_i && en_q && (nxt_i == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            cmp_q <= '0;
        end else begin
            if (ctl_we) en_q  <= wbit_i;
            if (cmp_we) cmp_q <= wval_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                    flag_q <= 1'b0;
        else if (hit)               flag_q <= 1'b1;
        else if (flag_we && wbit_i) flag_q <= 1'b0;
    end

    assign en_o   = en_q;
    assign flag_o = flag_q;
    assign cmp_o  = cmp_q;
    assign irq_o  = flag_q & en_q;

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(step_i && en_q)); // R6
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (flag_we && wbit_i && !step_i) |=> !flag_q); // R7
    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !(flag_we && wbit_i)) |=> flag_q); // R8
endmodule

// File: rtl/mctimer_top.sv
module mctimer_top
    import mct_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PSC_W  = 8,
    parameter int NCH    = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [CNT_W-1:0]  rdata,
    input  logic              dbg_halt,
    output logic [NCH-1:0]    irq
);
    localparam int BLK_W   = ADDR_W - 4;
    localparam int PSC_LSB = 8;

    logic             ctl_en, ctl_frz;
    logic [PSC_W-1:0] ctl_psc;
    logic             ctrl_we, cnt_we;
    logic [CNT_W-1:0] cnt, nxt;
    logic             step;

    logic [NCH-1:0]   ch_en, ch_flag;
    logic [CNT_W-1:0] ch_cmp [NCH];

    assign ctrl_we = wr_en && (addr == ADDR_W'(OFF_CTRL));
    assign cnt_we  = wr_en && (addr == ADDR_W'(OFF_COUNT));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_en  <= 1'b0;
            ctl_frz <= 1'b0;
            ctl_psc <= '0;
        end else if (ctrl_we) begin
            ctl_en  <= wdata[0];
            ctl_frz <= wdata[1];
            ctl_psc <= wdata[PSC_LSB +: PSC_W];
        end
    end

    mct_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
        .clk        (clk),
        .rst        (rst),
        .en_i       (ctl_en),
        .frz_i      (ctl_frz),
        .dbg_i      (dbg_halt),
        .psc_i      (ctl_psc),
        .load_i     (cnt_we),
        .load_val_i (wdata),
        .cnt_o      (cnt),
        .nxt_o      (nxt),
        .step_o     (step)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        localparam logic [BLK_W-1:0] BLK = BLK_W'(n + 1);
        logic sel;
        assign sel = wr_en && (addr[ADDR_W-1:4] == BLK);

        mct_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .step_i  (step),
            .nxt_i   (nxt),
            .ctl_we  (sel && addr[3:0] == 4'(SUB_CHCTL)),
            .flag_we (sel && addr[3:0] == 4'(SUB_CHFLAG)),
            .cmp_we  (sel && addr[3:0] == 4'(SUB_CHCMP)),
            .wbit_i  (wdata[0]),
            .wval_i  (wdata),
            .en_o    (ch_en[n]),
            .flag_o  (ch_flag[n]),
            .cmp_o   (ch_cmp[n]),
            .irq_o   (irq[n])
        );
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == ADDR_W'(OFF_CTRL)) begin
                rdata[0]                  = ctl_en;
                rdata[1]                  = ctl_frz;
                rdata[PSC_LSB +: PSC_W]   = ctl_psc;
            end else if (addr == ADDR_W'(OFF_COUNT)) begin
                rdata = cnt;
            end
            for (int n = 0; n < NCH; n++) begin
                if (addr[ADDR_W-1:4] == BLK_W'(n + 1)) begin
                    unique case (addr[3:0])
                        4'(SUB_CHCTL):  rdata[0] = ch_en[n];
                        4'(SUB_CHFLAG): rdata[0] = ch_flag[n];
                        4'(SUB_CHCMP):  rdata    = ch_cmp[n];
                        default:        rdata    = '0;
                    endcase
                end
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (irq == '0)); // R1
endmodule

// File: tb/sim_mctimer_top.sv
`timescale 1ns/1ps
module sim_mctimer_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0, dbg_halt = 1'b0;
    logic [31:0] rdata;
    logic [3:0]  irq;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mctimer_top u0 (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .dbg_halt(dbg_halt), .irq(irq)
    );

    typedef struct packed {
        logic        is_rd;
        logic [7:0]  a;
        logic [31:0] d;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VT [NV] = '{
        '{1'b1, 8'h00, 32'h0,        32'h0,        4'd1},  // R1 control
        '{1'b1, 8'h04, 32'h0,        32'h0,        4'd1},  // R1 counter
        '{1'b1, 8'h14, 32'h0,        32'h0,        4'd1},  // R1 ch0 flag
        '{1'b1, 8'h38, 32'h0,        32'h0,        4'd1},  // R1 ch2 compare
        '{1'b0, 8'h00, 32'hFFFFFFFF, 32'h0,        4'd10},
        '{1'b1, 8'h00, 32'h0,        32'h0000FF03, 4'd10}, // R10 reserved bits zero
        '{1'b0, 8'h00, 32'h0,        32'h0,        4'd10},
        '{1'b0, 8'h28, 32'hDEADBEEF, 32'h0,        4'd10},
        '{1'b1, 8'h28, 32'h0,        32'hDEADBEEF, 4'd10}, // R10 ch1 compare
        '{1'b0, 8'h30, 32'hFFFFFFFF, 32'h0,        4'd10},
        '{1'b1, 8'h30, 32'h0,        32'h1,        4'd10}, // R10 ch2 control
        '{1'b0, 8'h30, 32'h0,        32'h0,        4'd10},
        '{1'b1, 8'h08, 32'h0,        32'h0,        4'd10}, // R10 unmapped
        '{1'b1, 8'h50, 32'h0,        32'h0,        4'd10}, // R10 beyond channels
        '{1'b1, 8'h0C, 32'h0,        32'h0,        4'd10}, // R10 unmapped
        '{1'b1, 8'h29, 32'h0,        32'h0,        4'd10}, // R10 misaligned
        '{1'b0, 8'h34, 32'h0,        32'h0,        4'd7},
        '{1'b1, 8'h34, 32'h0,        32'h0,        4'd7}   // R7 writing 0
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v, a0, b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(irq == 4'h0, "R1", {28'h0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VT[i].is_rd) begin
                rd(VT[i].a, v);
                chk(v == VT[i].exp, $sformatf("R%0d vec%0d", VT[i].req, i), v, VT[i].exp);
            end else begin
                wr(VT[i].a, VT[i].d);
            end
        end

        // R2: disabled timer holds a loaded value
        wr(8'h00, 32'h0);
        wr(8'h04, 32'd5);
        idle(10);
        rd(8'h04, v);
        chk(v == 32'd5, "R2", v, 32'd5);

        // R3: tick spacing for three prescale values
        foreach (a0[i]) ; // no-op keeps a0 declared use simple
        for (int k = 0; k < 3; k++) begin
            int p;
            p = (k == 0) ? 0 : (k == 1) ? 3 : 255;
            wr(8'h00, 32'h1 | (32'(p) << 8));
            idle(3);
            rd(8'h04, a0);
            idle((p + 1) * 6 - 1);
            rd(8'h04, b0);
            chk(b0 - a0 == 32'd6, "R3", b0 - a0, 32'd6);
        end

        // R4: freeze with permit bit
        wr(8'h00, 32'h3);
        @(negedge clk); dbg_halt = 1'b1;
        idle(3);
        rd(8'h04, a0);
        idle(20);
        rd(8'h04, b0);
        chk(b0 == a0, "R4 frozen", b0, a0);
        dbg_halt = 1'b0;
        idle(5);
        rd(8'h04, b0);
        chk(b0 != a0, "R4 thaw", b0, a0 + 32'd6);
        // R4: without permit, debug-halt ignored
        wr(8'h00, 32'h1);
        dbg_halt = 1'b1;
        idle(2);
        rd(8'h04, a0);
        idle(10);
        rd(8'h04, b0);
        chk(b0 - a0 == 32'd11, "R4 ignored", b0 - a0, 32'd11);
        dbg_halt = 1'b0;

        // R5: load and wrap
        wr(8'h00, 32'h0);
        wr(8'h04, 32'hFFFFFFFD);
        rd(8'h04, v);
        chk(v == 32'hFFFFFFFD, "R5 load", v, 32'hFFFFFFFD);
        wr(8'h00, 32'h1);
        idle(8);
        rd(8'h04, v);
        chk(v < 32'h40, "R5 wrap", v, 32'h6);

        // R6: matches on channels 0 and 2, none on 3
        wr(8'h00, 32'h0);
        wr(8'h04, 32'd100);
        wr(8'h18, 32'd110); wr(8'h10, 32'h1);
        wr(8'h38, 32'd105); wr(8'h30, 32'h1);
        wr(8'h48, 32'd200); wr(8'h40, 32'h1);
        chk(irq == 4'h0, "R6 before", {28'h0, irq}, 32'h0);
        wr(8'h00, 32'h1);
        idle(30);
        chk(irq == 4'b0101, "R6 irq", {28'h0, irq}, 32'h5);
        rd(8'h14, v);
        chk(v == 32'h1, "R6 flag0", v, 32'h1);
        rd(8'h44, v);
        chk(v == 32'h0, "R6 flag3", v, 32'h0);

        // R7: write 0 keeps, write 1 clears
        wr(8'h14, 32'h0);
        rd(8'h14, v);
        chk(v == 32'h1, "R7 keep", v, 32'h1);
        wr(8'h14, 32'h1);
        rd(8'h14, v);
        chk(v == 32'h0 && irq[0] == 1'b0, "R7 clear", v, 32'h0);

        // R8: mask then re-expose
        wr(8'h30, 32'h0);
        rd(8'h34, v);
        chk(v == 32'h1 && irq[2] == 1'b0, "R8 masked", {v[30:0], irq[2]}, 32'h2);
        wr(8'h30, 32'h1);
        @(negedge clk);
        chk(irq[2] == 1'b1, "R8 exposed", {31'h0, irq[2]}, 32'h1);

        // R9: load onto compare does not match
        wr(8'h00, 32'h0);
        wr(8'h28, 32'd50); wr(8'h20, 32'h1);
        wr(8'h04, 32'd50);
        idle(5);
        rd(8'h24, v);
        chk(v == 32'h0 && irq[1] == 1'b0, "R9 load", v, 32'h0);
        // R9: resting on compare value between slow ticks
        wr(8'h04, 32'd49);
        wr(8'h00, 32'h0000FF01);
        for (int i = 0; i < 700 && !irq[1]; i++) @(negedge clk);
        chk(irq[1] == 1'b1, "R9 hit", {31'h0, irq[1]}, 32'h1);
        wr(8'h24, 32'h1);
        idle(50);
        rd(8'h04, v);
        chk(v == 32'd50, "R9 resting", v, 32'd50);
        rd(8'h24, v);
        chk(v == 32'h0, "R9 no refire", v, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule